// File: doc/BRIEF.md
# Refresh-Aware Command Admission Filter

This block sits between a command source and two memory-controller command queues, called queue A and queue B. While a rank is being refreshed, it holds back new commands that target that rank. The queues then keep their free entries for commands to other ranks, which can still be served.

The filter does not compare full rank addresses. It reduces each rank address to a 3-bit key and compares keys. A 3-bit mode input selects which rank-address bits form the key, to suit the slot, master-rank and stack layout of the memory. Each queue has its own enable bit.

A refresh is announced with a one-cycle start pulse that carries the rank under refresh, and it ends with a one-cycle done pulse. Commands use a valid/ready handshake on the way in and on the way out. A blocked command is held at the input with ready low. It is never dropped.

Top module: `refresh_admit_filter`

## Requirements
- R1: After reset no refresh is active: every queue passes `in_ready = out_ready` and `stall` is low.
- R2: A rank address is 6 bits, with d at bit 5, m1 at bit 4, m2 at bit 3, s2 at bit 2, s1 at bit 1 and s0 at bit 0. The mode selects the key bits as follows:
  - 0 uses s0, s1 and s2.
  - 1 uses m2, s1 and s2.
  - 2 uses d, s1 and s2.
  - 3 uses d, m2 and s2.
  - 4 uses d, m1 and m2.
  - Bits outside the selected set never affect a match.
- R3: A command on an enabled queue whose key equals the key of the rank under refresh is blocked: `out_valid` is low, `in_ready` is low and `stall` is high.
- R4: Each queue's blocking is controlled only by its own enable bit. A queue whose enable is low is never blocked.
- R5: With both enables low, the mode value has no effect and no command is blocked.
- R6: Mode values 5, 6 and 7 are reserved, and no command is blocked in them.
- R7: Blocking starts in the cycle after the start pulse, stays in force during the done cycle, and is released in the cycle after the done pulse.
- R8: If start and done arrive in the same cycle, start wins: the new rank is captured and refresh stays active, so blocking moves to the new rank from the next cycle.
- R9: A command that is not blocked passes straight through in the same cycle: `out_valid = in_valid` and `in_ready = out_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_start | input | 1 | Pulse: refresh of `ref_rank` begins |
| ref_done | input | 1 | Pulse: current refresh ends |
| ref_rank | input | 6 | Rank under refresh, laid out as in R2 |
| mode | input | 3 | Key selection mode |
| en_a | input | 1 | Blocking enable for queue A |
| en_b | input | 1 | Blocking enable for queue B |
| qa_in_valid | input | 1 | Queue A command valid from the source |
| qa_in_rank | input | 6 | Queue A command rank address |
| qa_in_ready | output | 1 | Queue A ready to the source |
| qa_out_valid | output | 1 | Queue A command valid to the queue |
| qa_out_ready | input | 1 | Queue A ready from the queue |
| qa_stall | output | 1 | Queue A command held by an active refresh |
| qb_in_valid | input | 1 | Queue B command valid from the source |
| qb_in_rank | input | 6 | Queue B command rank address |
| qb_in_ready | output | 1 | Queue B ready to the source |
| qb_out_valid | output | 1 | Queue B command valid to the queue |
| qb_out_ready | input | 1 | Queue B ready from the queue |
| qb_stall | output | 1 | Queue B command held by an active refresh |

## Verification
The hardest case to reach is a refresh handover: a done and a new start land in the same cycle, and afterwards blocking must follow the new rank rather than simply clear. The bench drives that overlap directly. It then places commands to the old rank and to the new rank on the two queues, and checks which of them is held. For each mode, the table vectors pair a command that differs from the refreshed rank only in unselected bits with one that differs in a selected bit, so that a wrong bit choice shows up as a wrong stall.

// File: rtl/refresh_admit_filter.sv
module refresh_admit_filter #(
  parameter int RANK_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_start,
  input  logic              ref_done,
  input  logic [RANK_W-1:0] ref_rank,
  input  logic [2:0]        mode,
  input  logic              en_a,
  input  logic              en_b,
  input  logic              qa_in_valid,
  input  logic [RANK_W-1:0] qa_in_rank,
  output logic              qa_in_ready,
  output logic              qa_out_valid,
  input  logic              qa_out_ready,
  output logic              qa_stall,
  input  logic              qb_in_valid,
  input  logic [RANK_W-1:0] qb_in_rank,
  output logic              qb_in_ready,
  output logic              qb_out_valid,
  input  logic              qb_out_ready,
  output logic              qb_stall
);
  localparam int D_B  = RANK_W - 1;
  localparam int M1_B = RANK_W - 2;
  localparam int M2_B = RANK_W - 3;
  localparam int S2_B = 2;
  localparam int S1_B = 1;
  localparam int S0_B = 0;

  function automatic logic [2:0] key_of(input logic [2:0] md, input logic [RANK_W-1:0] r);
    case (md)
      3'd0:    key_of = {r[S2_B], r[S1_B], r[S0_B]};
      3'd1:    key_of = {r[M2_B], r[S2_B], r[S1_B]};
      3'd2:    key_of = {r[D_B],  r[S2_B], r[S1_B]};
      3'd3:    key_of = {r[D_B],  r[M2_B], r[S2_B]};
      3'd4:    key_of = {r[D_B],  r[M2_B], r[M1_B]};
      default: key_of = 3'd0;
    endcase
  endfunction

  logic              active;
  logic [RANK_W-1:0] held_rank;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      held_rank <= '0;
    end else if (ref_start) begin
      active    <= 1'b1;
      held_rank <= ref_rank;
    end else if (ref_done) begin
      active    <= 1'b0;
    end
  end

  logic       live;
  logic [2:0] held_key;
  logic       blk_a, blk_b;

  assign live     = active && (mode <= 3'd4);
  assign held_key = key_of(mode, held_rank);
  assign blk_a    = en_a && live && (key_of(mode, qa_in_rank) == held_key);
  assign blk_b    = en_b && live && (key_of(mode, qb_in_rank) == held_key);

  assign qa_out_valid = qa_in_valid && !blk_a;
  assign qa_in_ready  = qa_out_ready && !blk_a;
  assign qa_stall     = qa_in_valid && blk_a;

  assign qb_out_valid = qb_in_valid && !blk_b;
  assign qb_in_ready  = qb_out_ready && !blk_b;
  assign qb_stall     = qb_in_valid && blk_b;
endmodule

// File: rtl/refresh_admit_filter_chk.sv
module refresh_admit_filter_chk #(
  parameter int RANK_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ref_start,
  input logic              ref_done,
  input logic [2:0]        mode,
  input logic              en_a,
  input logic              en_b,
  input logic              qa_in_valid,
  input logic              qa_in_ready,
  input logic              qa_out_valid,
  input logic              qa_stall,
  input logic              qb_in_valid,
  input logic              qb_in_ready,
  input logic              qb_out_valid,
  input logic              qb_stall
);
  // R3
  qa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qa_stall |-> (!qa_out_valid && !qa_in_ready));
  // R3
  qb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qb_stall |-> (!qb_out_valid && !qb_in_ready));
  // R4
  qa_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_a |-> !qa_stall);
  // R4
  qb_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_b |-> !qb_stall);
  // R6
  reserved_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode > 3'd4) |-> (!qa_stall && !qb_stall));
  // R7
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done && !ref_start) |=> (!qa_stall && !qb_stall));
  // R9
  qa_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qa_in_valid && !qa_stall) |-> qa_out_valid);
  // R9
  qb_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qb_in_valid && !qb_stall) |-> qb_out_valid);
endmodule

bind refresh_admit_filter refresh_admit_filter_chk #(.RANK_W(RANK_W)) u_chk (.*);

// File: tb/test_refresh_admit_filter.sv
module test_refresh_admit_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_start, ref_done;
  logic [5:0] ref_rank;
  logic [2:0] mode;
  logic       en_a, en_b;
  logic       qa_in_valid, qa_in_ready, qa_out_valid, qa_out_ready, qa_stall;
  logic       qb_in_valid, qb_in_ready, qb_out_valid, qb_out_ready, qb_stall;
  logic [5:0] qa_in_rank, qb_in_rank;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  refresh_admit_filter i_refresh_admit_filter (
    .clk(clk), .rst_n(rst_n), .ref_start(ref_start), .ref_done(ref_done),
    .ref_rank(ref_rank), .mode(mode), .en_a(en_a), .en_b(en_b),
    .qa_in_valid(qa_in_valid), .qa_in_rank(qa_in_rank), .qa_in_ready(qa_in_ready),
    .qa_out_valid(qa_out_valid), .qa_out_ready(qa_out_ready), .qa_stall(qa_stall),
    .qb_in_valid(qb_in_valid), .qb_in_rank(qb_in_rank), .qb_in_ready(qb_in_ready),
    .qb_out_valid(qb_out_valid), .qb_out_ready(qb_out_ready), .qb_stall(qb_stall)
  );

  // {mode, en_a, en_b, ref_rank, qa_rank, qb_rank, exp_stall_a, exp_stall_b}
  // rank bits: [5]=d [4]=m1 [3]=m2 [2]=s2 [1]=s1 [0]=s0
  localparam logic [24:0] VEC [0:10] = '{
    {3'd0, 1'b1, 1'b1, 6'b000101, 6'b111101, 6'b000100, 1'b1, 1'b0},
    {3'd1, 1'b1, 1'b1, 6'b001110, 6'b001111, 6'b000110, 1'b1, 1'b0},
    {3'd2, 1'b1, 1'b1, 6'b100010, 6'b110011, 6'b000010, 1'b1, 1'b0},
    {3'd3, 1'b1, 1'b1, 6'b101100, 6'b111101, 6'b101000, 1'b1, 1'b0},
    {3'd4, 1'b1, 1'b1, 6'b110000, 6'b110111, 6'b010000, 1'b1, 1'b0},
    {3'd4, 1'b0, 1'b1, 6'b011000, 6'b011000, 6'b011000, 1'b0, 1'b1},
    {3'd0, 1'b0, 1'b0, 6'b000011, 6'b000011, 6'b000011, 1'b0, 1'b0},
    {3'd7, 1'b0, 1'b0, 6'b000011, 6'b000011, 6'b000011, 1'b0, 1'b0},
    {3'd5, 1'b1, 1'b1, 6'b101010, 6'b101010, 6'b101010, 1'b0, 1'b0},
    {3'd6, 1'b1, 1'b1, 6'b101010, 6'b101010, 6'b101010, 1'b0, 1'b0},
    {3'd0, 1'b1, 1'b1, 6'b000011, 6'b000011, 6'b000001, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; ref_start = 1'b0; ref_done = 1'b0; ref_rank = '0;
    mode = 3'd0; en_a = 1'b1; en_b = 1'b1;
    qa_in_valid = 1'b1; qa_in_rank = '0; qa_out_ready = 1'b1;
    qb_in_valid = 1'b1; qb_in_rank = '0; qb_out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "qa_in_ready after reset", qa_in_ready, 1'b1);
    chk("R1", "qa_stall after reset", qa_stall, 1'b0);
    chk("R1", "qb_stall after reset", qb_stall, 1'b0);

    for (int i = 0; i < 11; i++) begin
      logic [24:0] v;
      logic xa, xb;
      string tag;
      v  = VEC[i];
      xa = v[1];
      xb = v[0];
      if (!v[21] && !v[20]) tag = "R5";
      else if (v[24:22] > 3'd4) tag = "R6";
      else if (!v[21] || !v[20]) tag = "R4";
      else tag = "R2";
      @(negedge clk);
      mode = v[24:22]; en_a = v[21]; en_b = v[20];
      ref_rank = v[19:14]; qa_in_rank = v[13:8]; qb_in_rank = v[7:2];
      qa_in_valid = 1'b1; qb_in_valid = 1'b1;
      ref_start = 1'b1;
      #5;
      chk("R7", "qa_stall in start cycle", qa_stall, 1'b0);
      chk("R7", "qb_stall in start cycle", qb_stall, 1'b0);
      @(negedge clk);
      ref_start = 1'b0;
      #5;
      chk(tag, "qa_stall", qa_stall, xa);
      chk(tag, "qb_stall", qb_stall, xb);
      chk("R3", "qa_in_ready", qa_in_ready, !xa);
      chk("R3", "qa_out_valid", qa_out_valid, !xa);
      chk("R3", "qb_out_valid", qb_out_valid, !xb);
      @(negedge clk);
      ref_done = 1'b1;
      #5;
      chk("R7", "qa_stall in done cycle", qa_stall, xa);
      chk("R7", "qb_stall in done cycle", qb_stall, xb);
      @(negedge clk);
      ref_done = 1'b0;
      #5;
      chk("R7", "qa_stall after done", qa_stall, 1'b0);
      chk("R7", "qb_stall after done", qb_stall, 1'b0);
    end

    // R8: done and a new start in the same cycle hand blocking over to the new rank
    @(negedge clk);
    mode = 3'd0; en_a = 1'b1; en_b = 1'b1;
    qa_in_rank = 6'b000001; qb_in_rank = 6'b000010;
    ref_rank = 6'b000001; ref_start = 1'b1;
    @(negedge clk);
    ref_start = 1'b0;
    #5;
    chk("R8", "qa_stall old rank", qa_stall, 1'b1);
    chk("R8", "qb_stall before handover", qb_stall, 1'b0);
    @(negedge clk);
    ref_done = 1'b1; ref_start = 1'b1; ref_rank = 6'b000010;
    @(negedge clk);
    ref_done = 1'b0; ref_start = 1'b0;
    #5;
    chk("R8", "qa_stall after handover", qa_stall, 1'b0);
    chk("R8", "qb_stall new rank", qb_stall, 1'b1);
    @(negedge clk);
    ref_done = 1'b1;
    @(negedge clk);
    ref_done = 1'b0;

    // R9: pass-through with no refresh active
    @(negedge clk);
    qa_out_ready = 1'b0; qb_out_ready = 1'b1; qb_in_valid = 1'b0;
    #5;
    chk("R9", "qa_in_ready follows out_ready low", qa_in_ready, 1'b0);
    chk("R9", "qa_out_valid follows in_valid", qa_out_valid, 1'b1);
    chk("R9", "qb_in_ready follows out_ready high", qb_in_ready, 1'b1);
    chk("R9", "qb_out_valid follows in_valid low", qb_out_valid, 1'b0);

    // R1: reset clears an active refresh
    @(negedge clk);
    qa_out_ready = 1'b1; qa_in_rank = 6'b000111;
    ref_rank = 6'b000111; ref_start = 1'b1;
    @(negedge clk);
    ref_start = 1'b0;
    #5;
    chk("R3", "qa_stall before reset", qa_stall, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1", "qa_stall after mid-refresh reset", qa_stall, 1'b0);
    chk("R1", "qa_in_ready after mid-refresh reset", qa_in_ready, 1'b1);

    summary();
  end
endmodule